// File: doc/BRIEF.md
# Interrupt Status and Mask Controller

This block gathers one-cycle event pulses from up to eleven peripheral sources and holds each one in a sticky status bit. A mask register selects which of the held events may interrupt the CPU. The block drives one registered request line that is high while some held and enabled event exists and the CPU reports that interrupts are enabled in two of its status bits.

Software uses a small word-addressed register port. Reads return the status or the mask word. A write to the mask replaces it. A write to the status ANDs the written word into the held bits. Writing a 0 to a bit acknowledges that bit, and writing a 1 leaves it as it is. An event pulse that arrives in the same cycle as an acknowledge is applied after the AND, so the event is never lost.

Top module: `irq_ctrl`

## Requirements
- R1: After reset the status and mask registers read as zero and `irq_o` is low.
- R2: A high bit on `src_pulse_i` sets the matching status bit at the next clock edge. The bit then stays set until a status write clears it.
- R3: A write to byte offset 0x70 makes the status equal to status AND write data. A 0 bit clears the matching status bit and a 1 bit leaves it unchanged.
- R4: When a source pulse and a status write that clears the same bit fall in one cycle, the bit reads as set after that edge.
- R5: A write to byte offset 0x74 replaces the mask with the write data, and a read at 0x74 returns the mask.
- R6: Only bits 10..0 exist. Read-data bits 31..11 are zero for both registers, and write-data bits above bit 10 have no effect.
- R7: `irq_o` is high after an edge exactly when (status AND mask) is nonzero in the registers updated at that edge and `cpu_stat_i` bits 0 and 10 were both high at that edge.
- R8: A mask write that makes (status AND mask) nonzero raises `irq_o` at the same edge that updates the mask, with no extra cycle.
- R9: Reads at offsets other than 0x70 and 0x74 return zero. Writes to those offsets change neither register.
- R10: `irq_o` is a level. It stays high on every cycle for as long as the qualified pending condition holds, with no pulses on the source inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_pulse_i | input | 11 | One-cycle event pulses, one bit per source |
| reg_addr_i | input | 8 | Byte offset in the register window |
| reg_we_i | input | 1 | Write strobe for the register port |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, decoded from `reg_addr_i` without a clock |
| cpu_stat_i | input | 16 | CPU status word; bits 0 and 10 enable the request |
| irq_o | output | 1 | Registered interrupt request level |

## Verification
The two functions that can fall in one cycle are a new source pulse and a status write that acknowledges bits. The second case is a mask write and a pulse that arrive together and change the request on that same edge. The bench sends a write that clears a bit while that bit's pulse is high, and it also mixes random pulses with random status and mask writes. After each edge it compares the status read-back and `irq_o` against a model that ORs the pulses in after the AND.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  typedef enum logic [1:0] {
    SEL_NONE   = 2'd0,
    SEL_STATUS = 2'd1,
    SEL_MASK   = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/irq_reg_decode.sv
module irq_reg_decode
  import irq_ctrl_pkg::*;
#(
  parameter int            ADDR_W     = 8,
  parameter logic [7:0]    STATUS_OFS = 8'h70,
  parameter logic [7:0]    MASK_OFS   = 8'h74
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  output reg_sel_e          sel_o,
  output logic              wr_status_o,
  output logic              wr_mask_o
);
  localparam logic [ADDR_W-1:0] StatusA = ADDR_W'(STATUS_OFS);
  localparam logic [ADDR_W-1:0] MaskA   = ADDR_W'(MASK_OFS);

  always_comb begin
    if (addr_i == StatusA)    sel_o = SEL_STATUS;
    else if (addr_i == MaskA) sel_o = SEL_MASK;
    else                      sel_o = SEL_NONE;
  end

  assign wr_status_o = we_i && (sel_o == SEL_STATUS);
  assign wr_mask_o   = we_i && (sel_o == SEL_MASK);

  always_comb begin
    assert_one_target_R9: assert (!(wr_status_o && wr_mask_o));
  end
endmodule

// File: rtl/irq_status_latch.sv
module irq_status_latch #(
  parameter int NUM_SRC = 11
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] pulse_i,
  input  logic               wr_i,
  input  logic [NUM_SRC-1:0] wdata_i,
  output logic [NUM_SRC-1:0] status_d_o,
  output logic [NUM_SRC-1:0] status_q_o
);
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
    logic kept;
    // ack first, then the new event, so a coincident pulse survives
    assign kept          = wr_i ? (status_q_o[i] & wdata_i[i]) : status_q_o[i];
    assign status_d_o[i] = kept | pulse_i[i];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) status_q_o[i] <= 1'b0;
      else         status_q_o[i] <= status_d_o[i];
    end

    assert_pulse_latched_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pulse_i[i] |=> status_q_o[i]);
    assert_ack_clears_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_i && !wdata_i[i] && !pulse_i[i]) |=> !status_q_o[i]);
    assert_pulse_beats_ack_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_i && !wdata_i[i] && pulse_i[i]) |=> status_q_o[i]);
    assert_sticky_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!wr_i && status_q_o[i]) |=> status_q_o[i]);
  end
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int NUM_SRC = 11
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  logic [NUM_SRC-1:0] wdata_i,
  output logic [NUM_SRC-1:0] mask_d_o,
  output logic [NUM_SRC-1:0] mask_q_o
);
  assign mask_d_o = wr_i ? wdata_i : mask_q_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mask_q_o <= '0;
    else         mask_q_o <= mask_d_o;
  end

  assert_mask_load_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (mask_q_o == $past(wdata_i)));
  assert_mask_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(mask_q_o));
endmodule

// File: rtl/irq_req_qual.sv
module irq_req_qual #(
  parameter int          NUM_SRC = 11,
  parameter int          CPU_W   = 16,
  parameter logic [15:0] EN_BITS = 16'h0401
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] status_d_i,
  input  logic [NUM_SRC-1:0] mask_d_i,
  input  logic [CPU_W-1:0]   cpu_stat_i,
  output logic               irq_o
);
  localparam logic [CPU_W-1:0] EnMask = CPU_W'(EN_BITS);

  logic cpu_ok;
  logic pend_d;

  assign cpu_ok = (cpu_stat_i & EnMask) == EnMask;
  // built from the next-state values so a mask write takes effect on its own edge
  assign pend_d = |(status_d_i & mask_d_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= 1'b0;
    else         irq_o <= pend_d && cpu_ok;
  end

  assert_cpu_gate_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cpu_ok |=> !irq_o);
  assert_level_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_d && cpu_ok) |=> irq_o);
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int          NUM_SRC    = 11,
  parameter int          ADDR_W     = 8,
  parameter int          DATA_W     = 32,
  parameter int          CPU_W      = 16,
  parameter logic [7:0]  STATUS_OFS = 8'h70,
  parameter logic [7:0]  MASK_OFS   = 8'h74,
  parameter logic [15:0] EN_BITS    = 16'h0401
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_pulse_i,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic               reg_we_i,
  input  logic [DATA_W-1:0]  reg_wdata_i,
  output logic [DATA_W-1:0]  reg_rdata_o,
  input  logic [CPU_W-1:0]   cpu_stat_i,
  output logic               irq_o
);
  reg_sel_e           sel;
  logic               wr_status, wr_mask;
  logic [NUM_SRC-1:0] wdata_lo;
  logic [NUM_SRC-1:0] status_d, status_q, mask_d, mask_q;
  logic               unused_wdata_hi;

  assign wdata_lo        = reg_wdata_i[NUM_SRC-1:0];
  assign unused_wdata_hi = |reg_wdata_i[DATA_W-1:NUM_SRC];

  irq_reg_decode #(
    .ADDR_W(ADDR_W), .STATUS_OFS(STATUS_OFS), .MASK_OFS(MASK_OFS)
  ) u_dec (
    .addr_i(reg_addr_i), .we_i(reg_we_i), .sel_o(sel),
    .wr_status_o(wr_status), .wr_mask_o(wr_mask)
  );

  irq_status_latch #(.NUM_SRC(NUM_SRC)) u_stat (
    .clk_i(clk_i), .rst_ni(rst_ni), .pulse_i(src_pulse_i), .wr_i(wr_status),
    .wdata_i(wdata_lo), .status_d_o(status_d), .status_q_o(status_q)
  );

  irq_mask_reg #(.NUM_SRC(NUM_SRC)) u_mask (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_mask), .wdata_i(wdata_lo),
    .mask_d_o(mask_d), .mask_q_o(mask_q)
  );

  irq_req_qual #(.NUM_SRC(NUM_SRC), .CPU_W(CPU_W), .EN_BITS(EN_BITS)) u_qual (
    .clk_i(clk_i), .rst_ni(rst_ni), .status_d_i(status_d), .mask_d_i(mask_d),
    .cpu_stat_i(cpu_stat_i), .irq_o(irq_o)
  );

  always_comb begin
    unique case (sel)
      SEL_STATUS: reg_rdata_o = DATA_W'(status_q);
      SEL_MASK:   reg_rdata_o = DATA_W'(mask_q);
      default:    reg_rdata_o = '0;
    endcase
  end

  assert_req_needs_pending_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (|(status_q & mask_q)));
  assert_mask_write_now_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_mask && |(status_d & wdata_lo) && ((cpu_stat_i & CPU_W'(EN_BITS)) == CPU_W'(EN_BITS)))
      |=> irq_o);
  always_comb begin
    assert_upper_zero_R6: assert (reg_rdata_o[DATA_W-1:NUM_SRC] == '0);
  end
endmodule

// File: tb/irq_ctrl_test.sv
module irq_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 11;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NS-1:0] pulse = '0;
  logic [7:0]    addr = '0;
  logic          we = 1'b0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [15:0]   cpu = 16'h0401;
  logic          irq;

  int n_tests = 0;
  int n_fail  = 0;
  logic [NS-1:0] m_stat = '0;
  logic [NS-1:0] m_mask = '0;
  logic          m_irq  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .src_pulse_i(pulse), .reg_addr_i(addr),
    .reg_we_i(we), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .cpu_stat_i(cpu), .irq_o(irq)
  );

  function automatic logic [NS-1:0] next_stat(logic [NS-1:0] s, logic w, logic [7:0] a,
                                              logic [31:0] d, logic [NS-1:0] p);
    logic [NS-1:0] t = (w && a == 8'h70) ? (s & d[NS-1:0]) : s;
    return t | p;
  endfunction

  function automatic logic [NS-1:0] next_mask(logic [NS-1:0] m, logic w, logic [7:0] a,
                                              logic [31:0] d);
    return (w && a == 8'h74) ? d[NS-1:0] : m;
  endfunction

  function automatic logic req_of(logic [NS-1:0] s, logic [NS-1:0] m, logic [15:0] c);
    return (|(s & m)) && c[0] && c[10];
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one clock step; inputs change on the falling edge
  task automatic step(logic [NS-1:0] p, logic w, logic [7:0] a, logic [31:0] d, logic [15:0] c);
    @(negedge clk);
    pulse = p; we = w; addr = a; wdata = d; cpu = c;
    m_stat = next_stat(m_stat, w, a, d, p);
    m_mask = next_mask(m_mask, w, a, d);
    m_irq  = req_of(m_stat, m_mask, c);
    @(posedge clk);
    #1;
    pulse = '0; we = 1'b0;
  endtask

  task automatic read_chk(string req, logic [7:0] a, logic [31:0] exp);
    addr = a; we = 1'b0;
    #1;
    check(req, rdata, exp);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    #(CLK_PERIOD * 3);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    read_chk("R1 status", 8'h70, 32'h0);
    read_chk("R1 mask", 8'h74, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);

    // R2 pulse latches and sticks
    step(11'h004, 0, 8'h00, 0, 16'h0401);
    read_chk("R2 latch", 8'h70, 32'h004);
    step('0, 0, 8'h00, 0, 16'h0401);
    step('0, 0, 8'h00, 0, 16'h0401);
    read_chk("R2 sticky", 8'h70, 32'h004);

    // R3 AND-write
    step(11'h089, 0, 8'h00, 0, 16'h0401);
    step('0, 1, 8'h70, 32'hFFFF_FFF7, 16'h0401);
    read_chk("R3 ack bit3 keep others", 8'h70, 32'h085);
    step('0, 1, 8'h70, 32'h0, 16'h0401);
    read_chk("R3 clear all", 8'h70, 32'h0);

    // R4 pulse beats coincident ack
    step(11'h200, 0, 8'h00, 0, 16'h0401);
    step(11'h200, 1, 8'h70, 32'h0, 16'h0401);
    read_chk("R4 coincident survives", 8'h70, 32'h200);

    // R5 / R6 mask write and width
    step('0, 1, 8'h74, 32'hFFFF_F000, 16'h0401);
    read_chk("R6 high bits ignored", 8'h74, 32'h0);
    check("R7 no pending", {31'b0, irq}, 32'h0);
    // R8 mask write raises irq on its own edge
    step('0, 1, 8'h74, 32'h0000_0200, 16'h0401);
    check("R8 irq on mask edge", {31'b0, irq}, 32'h1);
    read_chk("R5 mask readback", 8'h74, 32'h200);
    step('0, 1, 8'h74, 32'hFFFF_FFFF, 16'h0401);
    read_chk("R6 mask upper zero", 8'h74, 32'h7FF);

    // R10 level holds
    for (int k = 0; k < 4; k++) begin
      step('0, 0, 8'h00, 0, 16'h0401);
      check("R10 level", {31'b0, irq}, 32'h1);
    end

    // R7 CPU enable bits
    step('0, 0, 8'h00, 0, 16'h0001);
    check("R7 bit10 low", {31'b0, irq}, 32'h0);
    step('0, 0, 8'h00, 0, 16'h0400);
    check("R7 bit0 low", {31'b0, irq}, 32'h0);
    step('0, 0, 8'h00, 0, 16'hFFFF);
    check("R7 both high", {31'b0, irq}, 32'h1);

    // R9 other offsets
    step('0, 1, 8'h78, 32'h0, 16'h0401);
    read_chk("R9 status untouched", 8'h70, 32'h200);
    read_chk("R9 mask untouched", 8'h74, 32'h7FF);
    read_chk("R9 other reads zero", 8'h6C, 32'h0);

    // random mix
    for (int k = 0; k < 400; k++) begin
      logic [NS-1:0] p;
      logic w;
      logic [7:0] a;
      logic [31:0] d;
      logic [15:0] c;
      int sel;
      p = ($urandom % 3 == 0) ? NS'($urandom) & NS'($urandom) : '0;
      w = ($urandom % 2) == 1;
      sel = $urandom % 4;
      a = (sel == 0) ? 8'h74 : (sel == 3) ? 8'h7C : 8'h70;
      d = $urandom;
      c = ($urandom % 4 == 0) ? 16'($urandom) : 16'h0401;
      step(p, w, a, d, c);
      check("R7 random irq", {31'b0, irq}, {31'b0, m_irq});
      read_chk("R3 R4 random status", 8'h70, 32'(m_stat));
      read_chk("R5 random mask", 8'h74, 32'(m_mask));
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule